// File: doc/BRIEF.md
# Interrupt Coalescing Delay Timers

This block groups interrupt requests of a network controller so that a burst of completed descriptors produces one interrupt instead of many. It keeps two timer sets, one for the receive direction and one for the transmit direction. Each set has a packet delay timer and an absolute delay timer. The packet delay timer restarts on every completion, so it expires only after the link has been quiet for a while. The absolute delay timer starts once and cannot be restarted, so it bounds the total latency. When the delay values are zero, the timers are bypassed and the cause is posted immediately.

Both timers count down on an interval tick strobe, so one count is one interrupt clock period. When either timer of a set expires, the block raises a one-cycle cause pulse to the interrupt unit and stops both timers of that set. On the receive side it also flags packets whose length does not exceed a programmable small-packet threshold. The receive side also has a flush request that posts the receive cause at once. Masking, cause storage and descriptor handling belong to neighbouring blocks.

Top module: `intr_delay_timers`

## Requirements
- R1: After synchronous reset, all three cause outputs are 0 and no timer runs, so ticks alone produce no cause.
- R2: A receive completion with a nonzero packet delay P loads the receive packet timer with P. This also holds when the timer is already running, so a later completion restarts it. `rx_timer_cause_o` pulses in the cycle after the P-th tick that follows the loading completion.
- R3: A receive completion with a nonzero absolute delay A starts the receive absolute timer with A only if that timer is idle. The timer expires A ticks after the completion that started it, and later completions do not change it.
- R4: A receive completion with both receive delay values at zero pulses `rx_timer_cause_o` in the next cycle.
- R5: A receive completion with `rx_len_i <= rx_small_thr_i` pulses `rx_small_cause_o` in the next cycle. A completion with a longer packet does not pulse it.
- R6: The transmit packet timer is loaded with the transmit packet delay only by a completion with `tx_ide_i`=1 and a nonzero transmit packet delay. It then behaves as in R2 on `tx_timer_cause_o`.
- R7: The transmit absolute timer starts only on a completion with `tx_ide_i`=1, a nonzero transmit absolute delay, a nonzero transmit packet delay, and the timer idle. It is never restarted.
- R8: A transmit completion with `tx_ide_i`=0, or with a zero transmit packet delay, pulses `tx_timer_cause_o` in the next cycle and arms no transmit timer.
- R9: `rx_flush_i` pulses `rx_timer_cause_o` in the next cycle and does not disturb running receive timers.
- R10: The expiry of either timer of a set stops both timers of that set, so a burst gives one pulse. If a completion of that set falls in the expiry cycle, the expiry wins and the completion arms nothing.
- R11: Timers change only in cycles with `tick_i`=1. Each cause output is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Interval tick enable, one per interrupt clock period |
| rx_done_i | input | 1 | Receive descriptor completion strobe |
| rx_len_i | input | LEN_W | Length of the completed received packet |
| rx_small_thr_i | input | LEN_W | Small-packet threshold |
| rx_pkt_delay_i | input | DLY_W | Receive packet delay in ticks, 0 = disabled |
| rx_abs_delay_i | input | DLY_W | Receive absolute delay in ticks, 0 = disabled |
| rx_flush_i | input | 1 | Flush request, posts the receive cause at once |
| tx_done_i | input | 1 | Transmit descriptor completion strobe |
| tx_ide_i | input | 1 | Delay-enable flag of the completed transmit descriptor |
| tx_pkt_delay_i | input | DLY_W | Transmit packet delay in ticks, 0 = disabled |
| tx_abs_delay_i | input | DLY_W | Transmit absolute delay in ticks, 0 = disabled |
| rx_timer_cause_o | output | 1 | Receive timer cause pulse |
| rx_small_cause_o | output | 1 | Small-packet-detected cause pulse |
| tx_timer_cause_o | output | 1 | Transmit timer cause pulse |

## Verification
The key collision is a completion that wants to restart the packet timer in the same cycle that the absolute timer of the same set runs out. The bench provokes this by arming the receive set with a short absolute delay and a long packet delay. It then issues a second completion together with the tick that expires the absolute timer. The collision is judged correct when exactly one cause pulse appears and no further pulse follows over many later ticks, which shows that the new arm was discarded. A smaller overlap, a flush while a timer is running, is also checked: the immediate pulse appears and the pending timer still expires on schedule.

// File: rtl/intr_delay_pkg.sv
package intr_delay_pkg;

    localparam int DEF_DLY_W = 16;
    localparam int DEF_LEN_W = 14;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

endpackage

// File: rtl/coal_arm_logic.sv
module coal_arm_logic #(
    parameter int  DLY_W  = 16,
    parameter bit  IS_TX  = 1'b0
) (
    input  logic             done_i,
    input  logic             ide_i,
    input  logic             flush_i,
    input  logic [DLY_W-1:0] pkt_val_i,
    input  logic [DLY_W-1:0] abs_val_i,
    output logic             arm_pkt_o,
    output logic             arm_abs_o,
    output logic             post_now_o
);

    logic pkt_nz;
    logic abs_nz;
    logic eff_done;
    logic abs_gate;
    logic bypass;

    always_comb begin
        pkt_nz   = (pkt_val_i != '0);
        abs_nz   = (abs_val_i != '0);
        eff_done = done_i & ide_i;
        // transmit absolute timer also needs a packet delay; receive does not
        abs_gate = IS_TX ? pkt_nz : 1'b1;
        // receive bypass needs both values zero; transmit only the packet delay
        bypass   = IS_TX ? ~pkt_nz : (~pkt_nz & ~abs_nz);

        arm_pkt_o  = eff_done & pkt_nz;
        arm_abs_o  = eff_done & abs_nz & abs_gate;
        post_now_o = flush_i | (done_i & ~ide_i) | (eff_done & bypass);
    end

endmodule

// File: rtl/coal_timer_pair.sv
module coal_timer_pair #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             arm_pkt_i,
    input  logic             arm_abs_i,
    input  logic             post_now_i,
    input  logic [DLY_W-1:0] pkt_val_i,
    input  logic [DLY_W-1:0] abs_val_i,
    output logic             cause_o
);

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        logic [DLY_W-1:0] pcnt;
        logic             prun;
        logic [DLY_W-1:0] acnt;
        logic             arun;
        logic             cause;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     pkt_exp;
    logic     abs_exp;

    always_comb begin
        st_d    = st_q;
        pkt_exp = st_q.prun & tick_i & (st_q.pcnt == ONE);
        abs_exp = st_q.arun & tick_i & (st_q.acnt == ONE);

        if (st_q.prun && tick_i) st_d.pcnt = st_q.pcnt - ONE;
        if (st_q.arun && tick_i) st_d.acnt = st_q.acnt - ONE;

        // packet timer restarts on every arm
        if (arm_pkt_i) begin
            st_d.pcnt = pkt_val_i;
            st_d.prun = 1'b1;
        end
        // absolute timer starts only from idle
        if (arm_abs_i && !st_q.arun) begin
            st_d.acnt = abs_val_i;
            st_d.arun = 1'b1;
        end
        // any expiry ends the whole burst
        if (pkt_exp || abs_exp) begin
            st_d.prun = 1'b0;
            st_d.arun = 1'b0;
        end
        st_d.cause = pkt_exp | abs_exp | post_now_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cause_o = st_q.cause;

    // a running timer never holds zero, otherwise it would never expire
    assert_pkt_cnt_live_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.prun |-> (st_q.pcnt != '0));

    assert_abs_cnt_live_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.arun |-> (st_q.acnt != '0));

    // a running absolute timer only holds or counts down, never reloads
    assert_abs_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.arun |=> (!st_q.arun || st_q.acnt == $past(st_q.acnt)
                       || st_q.acnt == $past(st_q.acnt) - ONE));

    // expiry of the packet timer also ends the absolute timer
    assert_stop_both_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q.prun && tick_i && st_q.pcnt == ONE) |=> (!st_q.arun && cause_o));

    // without a tick, a running timer holds its count
    assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q.prun && !tick_i && !arm_pkt_i) |=> $stable(st_q.pcnt));

endmodule

// File: rtl/intr_delay_timers.sv
module intr_delay_timers
    import intr_delay_pkg::*;
#(
    parameter int DLY_W = DEF_DLY_W,
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             rx_done_i,
    input  logic [LEN_W-1:0] rx_len_i,
    input  logic [LEN_W-1:0] rx_small_thr_i,
    input  logic [DLY_W-1:0] rx_pkt_delay_i,
    input  logic [DLY_W-1:0] rx_abs_delay_i,
    input  logic             rx_flush_i,
    input  logic             tx_done_i,
    input  logic             tx_ide_i,
    input  logic [DLY_W-1:0] tx_pkt_delay_i,
    input  logic [DLY_W-1:0] tx_abs_delay_i,
    output logic             rx_timer_cause_o,
    output logic             rx_small_cause_o,
    output logic             tx_timer_cause_o
);

    localparam int NDIR = 2;

    logic             done_v  [NDIR];
    logic             ide_v   [NDIR];
    logic             flush_v [NDIR];
    logic [DLY_W-1:0] pkt_v   [NDIR];
    logic [DLY_W-1:0] abs_v   [NDIR];
    logic             cause_v [NDIR];

    always_comb begin
        done_v[DIR_RX]  = rx_done_i;
        ide_v[DIR_RX]   = 1'b1;
        flush_v[DIR_RX] = rx_flush_i;
        pkt_v[DIR_RX]   = rx_pkt_delay_i;
        abs_v[DIR_RX]   = rx_abs_delay_i;
        done_v[DIR_TX]  = tx_done_i;
        ide_v[DIR_TX]   = tx_ide_i;
        flush_v[DIR_TX] = 1'b0;
        pkt_v[DIR_TX]   = tx_pkt_delay_i;
        abs_v[DIR_TX]   = tx_abs_delay_i;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic arm_pkt;
        logic arm_abs;
        logic post_now;

        coal_arm_logic #(
            .DLY_W (DLY_W),
            .IS_TX (d == int'(DIR_TX))
        ) u_arm (
            .done_i     (done_v[d]),
            .ide_i      (ide_v[d]),
            .flush_i    (flush_v[d]),
            .pkt_val_i  (pkt_v[d]),
            .abs_val_i  (abs_v[d]),
            .arm_pkt_o  (arm_pkt),
            .arm_abs_o  (arm_abs),
            .post_now_o (post_now)
        );

        coal_timer_pair #(
            .DLY_W (DLY_W)
        ) u_pair (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick_i),
            .arm_pkt_i  (arm_pkt),
            .arm_abs_i  (arm_abs),
            .post_now_i (post_now),
            .pkt_val_i  (pkt_v[d]),
            .abs_val_i  (abs_v[d]),
            .cause_o    (cause_v[d])
        );
    end

    logic small_d, small_q;

    always_comb begin
        small_d = rx_done_i & (rx_len_i <= rx_small_thr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) small_q <= 1'b0;
        else     small_q <= small_d;
    end

    assign rx_timer_cause_o = cause_v[DIR_RX];
    assign tx_timer_cause_o = cause_v[DIR_TX];
    assign rx_small_cause_o = small_q;

    assert_rx_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_done_i && rx_pkt_delay_i == '0 && rx_abs_delay_i == '0)
        |=> rx_timer_cause_o);

    assert_small_needs_done_R5: assert property (@(posedge clk) disable iff (rst)
        rx_small_cause_o |-> $past(rx_done_i));

    assert_tx_no_ide_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_done_i && !tx_ide_i) |=> tx_timer_cause_o);

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        rx_flush_i |=> rx_timer_cause_o);

endmodule

// File: tb/intr_delay_timers_bench.sv
module intr_delay_timers_bench;

    localparam int DLY_W = 16;
    localparam int LEN_W = 14;
    localparam time CLK_P = 10ns;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_i = 1'b0;
    logic             rx_done_i = 1'b0;
    logic [LEN_W-1:0] rx_len_i = '0;
    logic [LEN_W-1:0] rx_small_thr_i = '0;
    logic [DLY_W-1:0] rx_pkt_delay_i = '0;
    logic [DLY_W-1:0] rx_abs_delay_i = '0;
    logic             rx_flush_i = 1'b0;
    logic             tx_done_i = 1'b0;
    logic             tx_ide_i = 1'b0;
    logic [DLY_W-1:0] tx_pkt_delay_i = '0;
    logic [DLY_W-1:0] tx_abs_delay_i = '0;
    logic             rx_timer_cause_o;
    logic             rx_small_cause_o;
    logic             tx_timer_cause_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    intr_delay_timers #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_intr_delay_timers (
        .clk              (clk),
        .rst              (rst),
        .tick_i           (tick_i),
        .rx_done_i        (rx_done_i),
        .rx_len_i         (rx_len_i),
        .rx_small_thr_i   (rx_small_thr_i),
        .rx_pkt_delay_i   (rx_pkt_delay_i),
        .rx_abs_delay_i   (rx_abs_delay_i),
        .rx_flush_i       (rx_flush_i),
        .tx_done_i        (tx_done_i),
        .tx_ide_i         (tx_ide_i),
        .tx_pkt_delay_i   (tx_pkt_delay_i),
        .tx_abs_delay_i   (tx_abs_delay_i),
        .rx_timer_cause_o (rx_timer_cause_o),
        .rx_small_cause_o (rx_small_cause_o),
        .tx_timer_cause_o (tx_timer_cause_o)
    );

    typedef struct packed {
        int pdly;
        int adly;
        int exp_ticks;   // 0 = immediate cause
        int len;
        int thr;
        int exp_small;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3, 0, 3,  64,    64, 1},
        '{0, 5, 5,  65,    64, 0},
        '{4, 2, 2,  10,     0, 0},
        '{2, 6, 2,   0,     0, 1},
        '{0, 0, 0, 100,   200, 1},
        '{1, 1, 1,   5,     4, 0},
        '{7, 3, 3,   1, 16383, 1},
        '{0, 0, 0, 300,   299, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: inputs already driven, returns after the next edge settles
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rx_complete();
        rx_done_i = 1'b1;
        cyc();
        rx_done_i = 1'b0;
    endtask

    task automatic tx_complete(input logic ide);
        tx_ide_i  = ide;
        tx_done_i = 1'b1;
        cyc();
        tx_done_i = 1'b0;
    endtask

    // apply ticks until the selected cause pulses; n = tick number or -1
    task automatic count_ticks(input bit is_tx, input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            tick_i = 1'b1;
            cyc();
            if (n < 0 && (is_tx ? tx_timer_cause_o : rx_timer_cause_o)) n = i;
        end
        tick_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) cyc();
        check("R1 rx cause after reset", int'(rx_timer_cause_o), 0);
        check("R1 small cause after reset", int'(rx_small_cause_o), 0);
        check("R1 tx cause after reset", int'(tx_timer_cause_o), 0);
        rst = 1'b0;
        cyc();
        count_ticks(1'b0, 6, n);
        check("R1 rx no cause from ticks alone", n, -1);

        // table walk: R2 packet, R3 absolute, R4 bypass, R5 small packet
        foreach (VECS[k]) begin
            rx_pkt_delay_i = DLY_W'(VECS[k].pdly);
            rx_abs_delay_i = DLY_W'(VECS[k].adly);
            rx_len_i       = LEN_W'(VECS[k].len);
            rx_small_thr_i = LEN_W'(VECS[k].thr);
            rx_complete();
            check($sformatf("R5 small flag vec %0d", k), int'(rx_small_cause_o), VECS[k].exp_small);
            if (VECS[k].exp_ticks == 0) begin
                check($sformatf("R4 bypass vec %0d", k), int'(rx_timer_cause_o), 1);
                cyc();
                check($sformatf("R11 pulse width vec %0d", k), int'(rx_timer_cause_o), 0);
            end else begin
                check($sformatf("R2/R3 no early cause vec %0d", k), int'(rx_timer_cause_o), 0);
                count_ticks(1'b0, 12, n);
                check($sformatf("R2 R3 expiry tick vec %0d", k), n, VECS[k].exp_ticks);
            end
        end
        rx_len_i = LEN_W'(1000);
        rx_small_thr_i = '0;

        // R2: a second completion restarts the packet timer
        rx_pkt_delay_i = 16'd4; rx_abs_delay_i = '0;
        rx_complete();
        tick_i = 1'b1; repeat (3) cyc(); tick_i = 1'b0;
        check("R2 no cause before restart", int'(rx_timer_cause_o), 0);
        rx_complete();
        count_ticks(1'b0, 10, n);
        check("R2 restart gives full delay", n, 4);

        // R3: a second completion does not restart the absolute timer
        rx_pkt_delay_i = '0; rx_abs_delay_i = 16'd5;
        rx_complete();
        tick_i = 1'b1; repeat (3) cyc(); tick_i = 1'b0;
        rx_complete();
        count_ticks(1'b0, 10, n);
        check("R3 absolute keeps running", n, 2);

        // R11: no tick, no progress; pulse is one cycle
        rx_pkt_delay_i = 16'd2; rx_abs_delay_i = '0;
        rx_complete();
        repeat (10) cyc();
        check("R11 idle cycles do not expire", int'(rx_timer_cause_o), 0);
        tick_i = 1'b1; cyc(); cyc(); tick_i = 1'b0;
        check("R11 cause after second tick", int'(rx_timer_cause_o), 1);
        cyc();
        check("R11 cause is single pulse", int'(rx_timer_cause_o), 0);

        // R9: flush posts at once and leaves the armed timer alone
        rx_pkt_delay_i = 16'd3;
        rx_complete();
        rx_flush_i = 1'b1; cyc(); rx_flush_i = 1'b0;
        check("R9 flush posts cause", int'(rx_timer_cause_o), 1);
        count_ticks(1'b0, 10, n);
        check("R9 timer survives flush", n, 3);

        // R10: completion in the cycle the absolute timer expires
        rx_pkt_delay_i = 16'd5; rx_abs_delay_i = 16'd2;
        rx_complete();
        tick_i = 1'b1; cyc();
        rx_done_i = 1'b1; cyc();
        rx_done_i = 1'b0; tick_i = 1'b0;
        check("R10 expiry posts despite completion", int'(rx_timer_cause_o), 1);
        count_ticks(1'b0, 12, n);
        check("R10 colliding completion armed nothing", n, -1);

        // R8: transmit without delay enable posts at once, arms nothing
        tx_pkt_delay_i = 16'd3; tx_abs_delay_i = 16'd2;
        tx_complete(1'b0);
        check("R8 no ide posts at once", int'(tx_timer_cause_o), 1);
        count_ticks(1'b1, 6, n);
        check("R8 no ide arms no timer", n, -1);

        // R6: transmit packet timer
        tx_abs_delay_i = '0;
        tx_complete(1'b1);
        check("R6 no immediate cause", int'(tx_timer_cause_o), 0);
        count_ticks(1'b1, 10, n);
        check("R6 tx packet expiry", n, 3);

        // R7/R8: absolute alone is not armed on transmit
        tx_pkt_delay_i = '0; tx_abs_delay_i = 16'd2;
        tx_complete(1'b1);
        check("R8 zero packet delay posts at once", int'(tx_timer_cause_o), 1);
        count_ticks(1'b1, 6, n);
        check("R7 absolute needs packet delay", n, -1);

        // R7: transmit absolute not restarted, beats restarted packet timer
        tx_pkt_delay_i = 16'd5; tx_abs_delay_i = 16'd2;
        tx_complete(1'b1);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        tx_complete(1'b1);
        count_ticks(1'b1, 10, n);
        check("R7 tx absolute not restarted", n, 1);
        check("R1 rx quiet during tx tests", int'(rx_timer_cause_o), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule